// File: doc/BRIEF.md
# LED Boost Driver Fault Supervisor

This block is the digital protection supervisor of a switching boost converter that drives a string of LEDs. It watches a set of already-conditioned flags and decides, on every clock, whether the power switch may run. Flags from the analog side are: over-voltage on the switch node, feedback below half of its regulation level, under-voltage on the supply, and over-temperature. Both the under-voltage and the over-temperature flag arrive with hysteresis already applied. The logic-level control pin also feeds the block. It enables the converter, and a long low on that pin requests shutdown.

An open load shows up as over-voltage together with low feedback. When both flags hold at every switching-cycle tick for a set number of consecutive ticks, the block latches an open-load fault and drops into shutdown. Only a full power-down through the control pin clears that latch. Under-voltage and over-temperature only hold the switch off, and the switch comes back by itself once their flags clear. Leaving shutdown produces a single-cycle start pulse. Downstream logic uses this pulse to restart soft-start and dimming-mode selection.

Top module: `led_fault_supervisor`

## Requirements
- R1: An open-load fault is declared when `ovp_flag` and `fb_low_flag` are both high at OPEN_CYCLES (default 8) consecutive `cycle_tick` pulses while the converter is running.
- R2: A tick at which either `ovp_flag` or `fb_low_flag` is low restarts the consecutive-tick count from zero. Clocks without a tick leave the count unchanged.
- R3: On the clock edge that follows the qualifying tick, `open_fault` goes high, `shutdown` goes high and `sw_en` goes low.
- R4: Once set, `open_fault` stays high, and the converter stays in shutdown, regardless of the comparator flags and of `ctrl_pin` low pulses shorter than the shutdown time.
- R5: `open_fault` clears only when `ctrl_pin` is held low for the shutdown time. The converter restarts only after `ctrl_pin` then returns high.
- R6: `ctrl_pin` held low for SHDN_CYCLES clocks (after a SYNC_STAGES-deep synchronizer) puts the block in shutdown. Shorter low pulses have no effect on `shutdown` or `sw_en`.
- R7: While `uvlo_flag` is high, `sw_en` is low. When the flag clears, `sw_en` returns without any action on `ctrl_pin`.
- R8: While `otp_flag` is high, `sw_en` is low. When the flag clears, `sw_en` returns without any action on `ctrl_pin`.
- R9: With several faults present, `sw_en` stays low until every one of them has cleared.
- R10: Each exit from shutdown, which occurs when `ctrl_pin` is high and no open-load fault is latched, produces exactly one `start_pulse` one clock wide.
- R11: During and right after reset, `shutdown` is 1 and `sw_en`, `open_fault` and `start_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | One-clock pulse per switching cycle |
| ovp_flag | input | 1 | Switch-node over-voltage comparator |
| fb_low_flag | input | 1 | Feedback below half of regulation |
| uvlo_flag | input | 1 | Supply under-voltage, hysteresis applied |
| otp_flag | input | 1 | Over-temperature, hysteresis applied |
| ctrl_pin | input | 1 | Asynchronous logic-level control pin |
| sw_en | output | 1 | Power switch may run |
| shutdown | output | 1 | Converter is in shutdown |
| open_fault | output | 1 | Latched open-load fault |
| start_pulse | output | 1 | One-clock pulse on leaving shutdown |

## Verification
A stuck or miscounting open-load counter appears as `open_fault` rising one tick too early or too late. The error shows one clock after the eighth qualifying tick. A latch that does not hold appears as `sw_en` and `start_pulse` returning while the control pin is still high, within a few clocks of a short low pulse. A wrong release rule for under-voltage or over-temperature is seen in the same cycle as a flag change: `sw_en` fails to follow the combined flags. A broken low-time qualifier either shuts the converter down on a short pulse or misses a long one. This shows at `shutdown` within SHDN_CYCLES plus the synchronizer depth.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic uv;
        logic ot;
        logic open_load;
    } hold_reasons_t;

    function automatic logic any_hold(input hold_reasons_t r);
        return r.uv | r.ot | r.open_load;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/ctrl_qualifier.sv
module ctrl_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int SHDN_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_pin,
    output logic ctrl_level,
    output logic ctrl_low_long
);
    localparam int CW = supv_pkg::cnt_width(SHDN_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(SHDN_CYCLES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ctrl_pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ctrl_pin};
            end
        end
    endgenerate

    assign ctrl_level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)                low_cnt <= '0;
        else if (ctrl_level)    low_cnt <= '0;
        else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    assign ctrl_low_long = (low_cnt == LIMIT);
endmodule

// File: rtl/open_load_detect.sv
module open_load_detect #(
    parameter int OPEN_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic ovp,
    input  logic fb_low,
    output logic detect
);
    localparam int CW = supv_pkg::cnt_width(OPEN_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(OPEN_CYCLES - 1);

    logic [CW-1:0] run_cnt;
    logic          both;

    assign both   = ovp & fb_low;
    assign detect = enable & tick & both & (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!both || detect) run_cnt <= '0;
            else                 run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/power_sequencer.sv
module power_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_level,
    input  logic ctrl_low_long,
    input  logic open_detect,
    output supv_pkg::pwr_state_e state,
    output logic open_latched,
    output logic start_pulse
);
    import supv_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= PWR_OFF;
            open_latched <= 1'b0;
            start_pulse  <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (ctrl_low_long)    open_latched <= 1'b0;
            else if (open_detect) open_latched <= 1'b1;
            case (state)
                PWR_ON: begin
                    if (open_detect || ctrl_low_long) state <= PWR_OFF;
                end
                default: begin
                    if (ctrl_level && !ctrl_low_long && !open_latched) begin
                        state       <= PWR_ON;
                        start_pulse <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor #(
    parameter int OPEN_CYCLES = 8,
    parameter int SHDN_CYCLES = 625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cycle_tick,
    input  logic ovp_flag,
    input  logic fb_low_flag,
    input  logic uvlo_flag,
    input  logic otp_flag,
    input  logic ctrl_pin,
    output logic sw_en,
    output logic shutdown,
    output logic open_fault,
    output logic start_pulse
);
    import supv_pkg::*;

    logic          ctrl_level;
    logic          ctrl_low_long;
    logic          open_detect;
    pwr_state_e    state;
    hold_reasons_t holds;

    ctrl_qualifier #(
        .SYNC_STAGES(SYNC_STAGES),
        .SHDN_CYCLES(SHDN_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctrl_pin     (ctrl_pin),
        .ctrl_level   (ctrl_level),
        .ctrl_low_long(ctrl_low_long)
    );

    open_load_detect #(
        .OPEN_CYCLES(OPEN_CYCLES)
    ) u_open (
        .clk   (clk),
        .rst   (rst),
        .enable(state == PWR_ON),
        .tick  (cycle_tick),
        .ovp   (ovp_flag),
        .fb_low(fb_low_flag),
        .detect(open_detect)
    );

    power_sequencer u_seq (
        .clk          (clk),
        .rst          (rst),
        .ctrl_level   (ctrl_level),
        .ctrl_low_long(ctrl_low_long),
        .open_detect  (open_detect),
        .state        (state),
        .open_latched (open_fault),
        .start_pulse  (start_pulse)
    );

    assign holds.uv        = uvlo_flag;
    assign holds.ot        = otp_flag;
    assign holds.open_load = open_fault;

    assign shutdown = (state == PWR_OFF);
    assign sw_en    = (state == PWR_ON) && !any_hold(holds);
endmodule

// File: rtl/led_fault_supervisor_chk.sv
module led_fault_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic cycle_tick,
    input logic ovp_flag,
    input logic fb_low_flag,
    input logic uvlo_flag,
    input logic otp_flag,
    input logic ctrl_pin,
    input logic sw_en,
    input logic shutdown,
    input logic open_fault,
    input logic start_pulse
);
    AST_OPEN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(open_fault) |-> $past(cycle_tick && ovp_flag && fb_low_flag)); // R1
    AST_OPEN_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(open_fault) |-> (shutdown && !sw_en)); // R3
    AST_OPEN_CLEAR_IN_SHDN: assert property (@(posedge clk) disable iff (rst)
        $fell(open_fault) |-> shutdown); // R5
    AST_UV_HOLD: assert property (@(posedge clk) disable iff (rst)
        uvlo_flag |-> !sw_en); // R7
    AST_OT_HOLD: assert property (@(posedge clk) disable iff (rst)
        otp_flag |-> !sw_en); // R8
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R10
    AST_START_LEAVES_SHDN: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (!shutdown && $past(shutdown))); // R10
    AST_NO_RESTART_LATCHED: assert property (@(posedge clk) disable iff (rst)
        open_fault |-> !start_pulse); // R4
endmodule

bind led_fault_supervisor led_fault_supervisor_chk u_chk (.*);

// File: tb/led_fault_supervisor_bench.sv
module led_fault_supervisor_bench;
    localparam int OPEN_CYCLES = 8;
    localparam int SHDN_CYCLES = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cycle_tick = 1'b0, ovp_flag = 1'b0, fb_low_flag = 1'b0;
    logic uvlo_flag = 1'b0, otp_flag = 1'b0, ctrl_pin = 1'b0;
    logic sw_en, shutdown, open_fault, start_pulse;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    logic prev_start = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    led_fault_supervisor #(
        .OPEN_CYCLES(OPEN_CYCLES),
        .SHDN_CYCLES(SHDN_CYCLES),
        .SYNC_STAGES(2)
    ) u_led_fault_supervisor (.*);

    always @(negedge clk) begin
        if (start_pulse) starts++;
        if (start_pulse && prev_start) begin
            errors++;
            $display("FAIL R10 start_pulse wider than one clock: act=1 exp=0");
        end
        prev_start = start_pulse;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cycle_tick = 1'b1;
            @(negedge clk) cycle_tick = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic ctrl_low(input int n);
        @(negedge clk) ctrl_pin = 1'b0;
        repeat (n) @(negedge clk);
        ctrl_pin = 1'b1;
        repeat (SHDN_CYCLES / 2) @(negedge clk);
    endtask

    typedef struct packed {
        logic uv, ot, ov, fb;
        logic [4:0] n;
        logic e_sw, e_sd, e_of;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0},  // run
        '{1'b1, 1'b0, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0},  // R7 uv
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0},  // R7 release
        '{1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0},  // R8 ot
        '{1'b1, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0},  // R9 both
        '{1'b0, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0},  // R9 one left
        '{1'b0, 1'b0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0},  // R8 release
        '{1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0},  // R1 partial
        '{1'b0, 1'b0, 1'b1, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0},  // R2 restart
        '{1'b0, 1'b0, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 1'b0},  // R2 seven only
        '{1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0},  // R2 restart
        '{1'b0, 1'b0, 1'b1, 1'b1, 5'd8, 1'b0, 1'b1, 1'b1}   // R1 R3 eight
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        chk("R11 shutdown in reset", shutdown, 1'b1);
        chk("R11 sw_en in reset", sw_en, 1'b0);
        chk("R11 open_fault in reset", open_fault, 1'b0);
        chk("R11 start_pulse in reset", start_pulse, 1'b0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 shutdown after reset, pin low", shutdown, 1'b1);

        s0 = starts;
        ctrl_pin = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 running after enable", shutdown, 1'b0);
        chk_int("R10 one start pulse", starts - s0, 1);

        for (int i = 0; i < NV; i++) begin
            uvlo_flag   = VEC[i].uv;
            otp_flag    = VEC[i].ot;
            ovp_flag    = VEC[i].ov;
            fb_low_flag = VEC[i].fb;
            ticks(int'(VEC[i].n));
            chk($sformatf("R1-table[%0d] sw_en", i), sw_en, VEC[i].e_sw);
            chk($sformatf("R3-table[%0d] shutdown", i), shutdown, VEC[i].e_sd);
            chk($sformatf("R3-table[%0d] open_fault", i), open_fault, VEC[i].e_of);
        end

        // R4 latch survives cleared comparators
        ovp_flag = 1'b0; fb_low_flag = 1'b0;
        ticks(3);
        chk("R4 latch holds", open_fault, 1'b1);
        chk("R4 switch stays off", sw_en, 1'b0);

        // R4 short low pulse does not clear or restart
        s0 = starts;
        ctrl_low(SHDN_CYCLES / 2);
        chk("R4 short pulse keeps latch", open_fault, 1'b1);
        chk("R4 short pulse keeps shutdown", shutdown, 1'b1);
        chk_int("R4 no restart while latched", starts - s0, 0);

        // R5 long low clears latch, restart on high
        @(negedge clk) ctrl_pin = 1'b0;
        repeat (SHDN_CYCLES + 10) @(negedge clk);
        chk("R5 latch cleared by long low", open_fault, 1'b0);
        chk("R5 still shut down while pin low", shutdown, 1'b1);
        s0 = starts;
        ctrl_pin = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 restart after re-enable", shutdown, 1'b0);
        chk("R5 switch running again", sw_en, 1'b1);
        chk_int("R10 one start on restart", starts - s0, 1);

        // R6 short pulse while running
        ctrl_low(SHDN_CYCLES / 2);
        chk("R6 short pulse ignored shutdown", shutdown, 1'b0);
        chk("R6 short pulse ignored sw_en", sw_en, 1'b1);

        // R6 long low shuts down
        @(negedge clk) ctrl_pin = 1'b0;
        repeat (SHDN_CYCLES + 10) @(negedge clk);
        chk("R6 long low shuts down", shutdown, 1'b1);
        chk("R6 switch off after long low", sw_en, 1'b0);

        // R11 reset while running
        ctrl_pin = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 reset forces shutdown", shutdown, 1'b1);
        chk("R11 reset clears start_pulse", start_pulse, 1'b0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 start after reset with pin high", shutdown, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule